// File: doc/BRIEF.md
# Register-Controlled Traffic Source and Sink

This block drives and consumes test traffic on a 64-bit FIFO-style data path. A small register file, reached through a simple single-cycle register port, holds the transmit length and the command word. It also gives read access to a reset/status word, a FIFO status word and the live word counters.

Once started, the source pushes an incrementing pattern into a transmit FIFO and holds back whenever that FIFO reports full. The sink pops a receive FIFO on every cycle that the FIFO is not empty. When verification is enabled, it compares each returned word with the same pattern generated locally. A mismatch sets a sticky error flag.

Software sets the length, writes the command word to start a run and clear the counters, and then polls the busy flag, the counters and the error flag.

Top module: `trafgen_chk`

## Requirements
- R1: The register area is selected when address bits [15:8] equal 0x10. Within the area, offset 0x00 is the transmit length, 0x04 the command, 0x08 the reset/status word, 0x0C the FIFO status and 0x10 the receive count. A read of any other address returns zero.
- R2: `reg_rd_valid` is high exactly in the cycle after a cycle with `reg_rd_req` high. In that cycle `reg_rd_data` carries the value selected by the address presented with the request.
- R3: While a run is active, `tx_wr_en` is low in every cycle that `tx_full` is high. The run ends after the number of words written to offset 0x00 (valid range 1 to 0xFFFFFFFF) has been sent. A read of offset 0x00 returns the number of words sent so far.
- R4: Word n of a run (counting from 0) carries the low 32 bits of 2n in bits [31:0] and of 2n+1 in bits [63:32].
- R5: `rx_rd_en` is the inverse of `rx_empty`. Each popped word is taken one cycle after the pop, and a read of offset 0x10 returns the number of words taken.
- R6: With verification enabled, a taken word that differs from pattern word n (n = the receive count) sets command read bit 1. The bit stays set until the next command write or reset. With verification disabled, no word sets it.
- R7: A command write with bit 0 = 0 starts a run, and with bit 0 = 1 stops it. Bit 1 of the written value enables verification. Every command write clears both word counters and the error flag. Command read bit 0 is the busy flag.
- R8: Writing 1 to reset-word bit 0 clears the run, both counters and the error flag in that cycle, and the bit reads back as 0.
- R9: Reset-word bit 8 latches a high `irq_in` and is cleared by writing 1 to bit 8. Bit 16 reads `link_up`.
- R10: FIFO status bits [15:0] read `rx_level` and bit 31 reads `tx_full`. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_addr | input | 16 | Register byte address |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_req | input | 1 | Register read request |
| reg_rd_valid | output | 1 | Read data valid |
| reg_rd_data | output | 32 | Read data |
| irq_in | input | 1 | Interrupt input to latch |
| link_up | input | 1 | Link status input |
| rx_level | input | 16 | Receive FIFO fill level |
| tx_full | input | 1 | Transmit FIFO full |
| tx_wr_en | output | 1 | Transmit FIFO write enable |
| tx_wr_data | output | 64 | Transmit FIFO write data |
| rx_empty | input | 1 | Receive FIFO empty |
| rx_rd_en | output | 1 | Receive FIFO read enable |
| rx_rd_data | input | 64 | Receive FIFO read data, valid the cycle after a pop |

## Verification
The bench stalls the transmit FIFO at random. A source that ignored full would write during a stall, and one that stopped on the wrong count would send one word too few or too many; the one-word run catches the second mistake at its tightest.

The receive model delivers data one cycle after each pop, behind random empty gaps. A sink that compared in the pop cycle would flag every good stream as corrupt.

A single corrupted word must raise the flag and keep it raised through the good words that follow. The same corruption must leave the flag clear when verification is off. The soft reset is issued in the middle of a stalled run, and it must drop busy and zero the count.

// File: rtl/trafgen_pkg.sv
package trafgen_pkg;
   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_TXLEN,
      SEL_CMD,
      SEL_RST,
      SEL_FFSTS,
      SEL_RXLEN
   } reg_sel_e;

   localparam logic [7:0] OFS_TXLEN = 8'h00;
   localparam logic [7:0] OFS_CMD   = 8'h04;
   localparam logic [7:0] OFS_RST   = 8'h08;
   localparam logic [7:0] OFS_FFSTS = 8'h0C;
   localparam logic [7:0] OFS_RXLEN = 8'h10;
endpackage

// File: rtl/trafgen_pattern.sv
module trafgen_pattern #(
   parameter int DATA_W = 64,
   parameter int CNT_W  = 32
) (
   input  logic [CNT_W-1:0]  idx,
   output logic [DATA_W-1:0] word
);
   localparam int LANES = DATA_W / 32;

   generate
      if (DATA_W % 32 != 0 || DATA_W < 32) begin : g_bad_width
         $error("trafgen_pattern: DATA_W must be a multiple of 32");
      end
      for (genvar lane = 0; lane < LANES; lane++) begin : g_lane
         assign word[lane*32 +: 32] = 32'(idx) * 32'(LANES) + 32'(lane);
      end
   endgenerate
endmodule

// File: rtl/trafgen_regs.sv
module trafgen_regs
   import trafgen_pkg::*;
#(
   parameter int ADDR_W  = 16,
   parameter int CNT_W   = 32,
   parameter int LVL_W   = 16,
   parameter int AREA_ID = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr_en,
   input  logic [31:0]       reg_wr_data,
   input  logic              reg_rd_req,
   output logic              reg_rd_valid,
   output logic [31:0]       reg_rd_data,
   input  logic              irq_in,
   input  logic              link_up,
   input  logic [LVL_W-1:0]  rx_level,
   input  logic              tx_full,
   input  logic [CNT_W-1:0]  tx_cnt,
   input  logic [CNT_W-1:0]  rx_cnt,
   input  logic              busy,
   input  logic              err_flag,
   output logic              cmd_wr,
   output logic              cmd_go,
   output logic              soft_rst,
   output logic              verify_en,
   output logic [CNT_W-1:0]  tx_len
);
   localparam int HI_W = ADDR_W - 8;
   localparam logic [HI_W-1:0] AREA_HI = HI_W'(AREA_ID);

   generate
      if (ADDR_W < 9 || LVL_W > 16 || CNT_W > 32) begin : g_bad_cfg
         $error("trafgen_regs: unsupported address, level or counter width");
      end
   endgenerate

   reg_sel_e   sel;
   logic       rst_wr;
   logic       irq_flag;
   logic [31:0] rd_mux;

   always_comb begin
      sel = SEL_NONE;
      if (reg_addr[ADDR_W-1:8] == AREA_HI) begin
         unique case (reg_addr[7:0])
            OFS_TXLEN: sel = SEL_TXLEN;
            OFS_CMD:   sel = SEL_CMD;
            OFS_RST:   sel = SEL_RST;
            OFS_FFSTS: sel = SEL_FFSTS;
            OFS_RXLEN: sel = SEL_RXLEN;
            default:   sel = SEL_NONE;
         endcase
      end
   end

   assign cmd_wr   = reg_wr_en && (sel == SEL_CMD);
   assign cmd_go   = cmd_wr && !reg_wr_data[0];
   assign rst_wr   = reg_wr_en && (sel == SEL_RST);
   assign soft_rst = rst_wr && reg_wr_data[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_len    <= '0;
         verify_en <= 1'b0;
         irq_flag  <= 1'b0;
      end else begin
         if (reg_wr_en && sel == SEL_TXLEN) tx_len <= reg_wr_data[CNT_W-1:0];
         if (cmd_wr) verify_en <= reg_wr_data[1];
         if (irq_in) irq_flag <= 1'b1;
         else if (rst_wr && reg_wr_data[8]) irq_flag <= 1'b0;
      end
   end

   always_comb begin
      rd_mux = '0;
      unique case (sel)
         SEL_TXLEN: rd_mux = 32'(tx_cnt);
         SEL_CMD:   rd_mux = {30'd0, err_flag, busy};
         SEL_RST:   rd_mux = {15'd0, link_up, 7'd0, irq_flag, 8'd0};
         SEL_FFSTS: rd_mux = {tx_full, 15'd0, 16'(rx_level)};
         SEL_RXLEN: rd_mux = 32'(rx_cnt);
         default:   rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reg_rd_valid <= 1'b0;
         reg_rd_data  <= '0;
      end else begin
         reg_rd_valid <= reg_rd_req;
         if (reg_rd_req) reg_rd_data <= rd_mux;
      end
   end
endmodule

// File: rtl/trafgen_src.sv
module trafgen_src #(
   parameter int DATA_W = 64,
   parameter int CNT_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              soft_rst,
   input  logic              cmd_wr,
   input  logic              cmd_go,
   input  logic [CNT_W-1:0]  tx_len,
   input  logic              tx_full,
   output logic              tx_wr_en,
   output logic [DATA_W-1:0] tx_wr_data,
   output logic [CNT_W-1:0]  tx_cnt,
   output logic              busy
);
   logic [CNT_W-1:0] cnt_nxt;

   assign tx_wr_en = busy && !tx_full;
   assign cnt_nxt  = tx_cnt + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         tx_cnt <= '0;
      end else if (soft_rst) begin
         busy   <= 1'b0;
         tx_cnt <= '0;
      end else if (cmd_wr) begin
         busy   <= cmd_go;
         tx_cnt <= '0;
      end else if (tx_wr_en) begin
         tx_cnt <= cnt_nxt;
         if (cnt_nxt == tx_len) busy <= 1'b0;
      end
   end

   trafgen_pattern #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_pat (
      .idx  (tx_cnt),
      .word (tx_wr_data)
   );
endmodule

// File: rtl/trafgen_sink.sv
module trafgen_sink #(
   parameter int DATA_W = 64,
   parameter int CNT_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              soft_rst,
   input  logic              cmd_wr,
   input  logic              verify_en,
   input  logic              rx_empty,
   input  logic [DATA_W-1:0] rx_rd_data,
   output logic              rx_rd_en,
   output logic [CNT_W-1:0]  rx_cnt,
   output logic              err_flag
);
   logic              pop_q;
   logic [DATA_W-1:0] exp_word;

   assign rx_rd_en = !rx_empty;

   trafgen_pattern #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_pat (
      .idx  (rx_cnt),
      .word (exp_word)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pop_q <= 1'b0;
      end else if (soft_rst) begin
         pop_q <= 1'b0;
      end else begin
         pop_q <= rx_rd_en;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_cnt   <= '0;
         err_flag <= 1'b0;
      end else if (soft_rst || cmd_wr) begin
         rx_cnt   <= '0;
         err_flag <= 1'b0;
      end else if (pop_q) begin
         rx_cnt <= rx_cnt + 1'b1;
         if (verify_en && rx_rd_data != exp_word) err_flag <= 1'b1;
      end
   end
endmodule

// File: rtl/trafgen_chk.sv
module trafgen_chk #(
   parameter int DATA_W  = 64,
   parameter int CNT_W   = 32,
   parameter int ADDR_W  = 16,
   parameter int LVL_W   = 16,
   parameter int AREA_ID = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr_en,
   input  logic [31:0]       reg_wr_data,
   input  logic              reg_rd_req,
   output logic              reg_rd_valid,
   output logic [31:0]       reg_rd_data,
   input  logic              irq_in,
   input  logic              link_up,
   input  logic [LVL_W-1:0]  rx_level,
   input  logic              tx_full,
   output logic              tx_wr_en,
   output logic [DATA_W-1:0] tx_wr_data,
   input  logic              rx_empty,
   output logic              rx_rd_en,
   input  logic [DATA_W-1:0] rx_rd_data
);
   logic             cmd_wr;
   logic             cmd_go;
   logic             soft_rst;
   logic             verify_en;
   logic             busy;
   logic             err_flag;
   logic [CNT_W-1:0] tx_len;
   logic [CNT_W-1:0] tx_cnt;
   logic [CNT_W-1:0] rx_cnt;

   trafgen_regs #(
      .ADDR_W(ADDR_W), .CNT_W(CNT_W), .LVL_W(LVL_W), .AREA_ID(AREA_ID)
   ) u_regs (
      .clk, .rst_n, .reg_addr, .reg_wr_en, .reg_wr_data, .reg_rd_req,
      .reg_rd_valid, .reg_rd_data, .irq_in, .link_up, .rx_level, .tx_full,
      .tx_cnt, .rx_cnt, .busy, .err_flag, .cmd_wr, .cmd_go, .soft_rst,
      .verify_en, .tx_len
   );

   trafgen_src #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_src (
      .clk, .rst_n, .soft_rst, .cmd_wr, .cmd_go, .tx_len, .tx_full,
      .tx_wr_en, .tx_wr_data, .tx_cnt, .busy
   );

   trafgen_sink #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_sink (
      .clk, .rst_n, .soft_rst, .cmd_wr, .verify_en, .rx_empty, .rx_rd_data,
      .rx_rd_en, .rx_cnt, .err_flag
   );
endmodule

// File: rtl/trafgen_chk_sva.sv
module trafgen_chk_sva #(
   parameter int CNT_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             reg_rd_req,
   input logic             reg_rd_valid,
   input logic             tx_full,
   input logic             tx_wr_en,
   input logic             rx_empty,
   input logic             rx_rd_en,
   input logic             cmd_wr,
   input logic             soft_rst,
   input logic             err_flag,
   input logic             busy,
   input logic [CNT_W-1:0] tx_cnt
);
   p_rd_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rd_req |=> reg_rd_valid);

   p_rd_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_rd_req |=> !reg_rd_valid);

   p_full_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
      tx_full |-> !tx_wr_en);

   p_tx_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_wr_en && !cmd_wr && !soft_rst) |=> (tx_cnt == $past(tx_cnt) + 1'b1));

   p_no_pop_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rx_empty |-> !rx_rd_en);

   p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (err_flag && !cmd_wr && !soft_rst) |=> err_flag);

   p_soft_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (!busy && !err_flag && tx_cnt == '0));
endmodule

bind trafgen_chk trafgen_chk_sva #(.CNT_W(CNT_W)) u_sva (
   .clk, .rst_n, .reg_rd_req, .reg_rd_valid, .tx_full, .tx_wr_en,
   .rx_empty, .rx_rd_en, .cmd_wr, .soft_rst, .err_flag, .busy, .tx_cnt
);

// File: tb/trafgen_chk_tb.sv
module trafgen_chk_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam logic [15:0] A_TXLEN = 16'h1000;
   localparam logic [15:0] A_CMD   = 16'h1004;
   localparam logic [15:0] A_RST   = 16'h1008;
   localparam logic [15:0] A_FFSTS = 16'h100C;
   localparam logic [15:0] A_RXLEN = 16'h1010;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] reg_addr = '0;
   logic        reg_wr_en = 1'b0;
   logic [31:0] reg_wr_data = '0;
   logic        reg_rd_req = 1'b0;
   logic        reg_rd_valid;
   logic [31:0] reg_rd_data;
   logic        irq_in = 1'b0;
   logic        link_up = 1'b0;
   logic [15:0] rx_level = '0;
   logic        tx_full;
   logic        tx_wr_en;
   logic [63:0] tx_wr_data;
   logic        rx_empty;
   logic        rx_rd_en;
   logic [63:0] rx_rd_data;

   int n_chk = 0, n_err = 0, mon_chk = 0, mon_err = 0;
   logic force_full = 1'b0;
   logic full_rnd = 1'b0;
   logic rx_stall = 1'b0;
   int   tx_seen = 0, tx_base = 0;
   logic [63:0] rxq [0:255];
   logic [7:0]  rx_head = '0;
   logic [7:0]  rx_n = '0;
   logic [63:0] rx_out = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   trafgen_chk dut_i (
      .clk, .rst_n, .reg_addr, .reg_wr_en, .reg_wr_data, .reg_rd_req,
      .reg_rd_valid, .reg_rd_data, .irq_in, .link_up, .rx_level, .tx_full,
      .tx_wr_en, .tx_wr_data, .rx_empty, .rx_rd_en, .rx_rd_data
   );

   function automatic logic [63:0] pat(input int n);
      logic [31:0] lo;
      lo = 32'(n) * 32'd2;
      return {lo + 32'd1, lo};
   endfunction

   assign tx_full    = force_full | full_rnd;
   assign rx_empty   = rx_stall | (rx_head == rx_n);
   assign rx_rd_data = rx_out;

   always @(negedge clk) begin
      full_rnd <= ($urandom % 4) == 0;
      rx_stall <= ($urandom % 3) == 0;
   end

   always @(posedge clk) begin
      if (rst_n && rx_rd_en) begin
         rx_out  <= rxq[rx_head];
         rx_head <= rx_head + 8'd1;
      end
   end

   // R3 / R4 monitor on the transmit port
   always @(posedge clk) begin
      if (rst_n && tx_wr_en) begin
         mon_chk = mon_chk + 1;
         if (tx_full) begin
            mon_err = mon_err + 1;
            $display("FAIL R3 write while full: act=1 exp=0");
         end
         if (tx_wr_data !== pat(tx_seen - tx_base)) begin
            mon_err = mon_err + 1;
            $display("FAIL R4 word %0d: act=%h exp=%h", tx_seen - tx_base,
                     tx_wr_data, pat(tx_seen - tx_base));
         end
         tx_seen = tx_seen + 1;
      end
   end

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic reg_write(input logic [15:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_wr_data = d; reg_wr_en = 1'b1;
      @(negedge clk);
      reg_wr_en = 1'b0;
   endtask

   task automatic reg_read(input logic [15:0] a, output logic [31:0] d, output logic v);
      @(negedge clk);
      reg_addr = a; reg_rd_req = 1'b1;
      @(negedge clk);
      reg_rd_req = 1'b0;
      v = reg_rd_valid;
      d = reg_rd_data;
   endtask

   task automatic rd_chk(input string req, input logic [15:0] a, input logic [31:0] exp);
      logic [31:0] d;
      logic v;
      reg_read(a, d, v);
      check({req, " valid"}, 64'(v), 64'd1);
      check(req, 64'(d), 64'(exp));
   endtask

   task automatic wait_idle();
      logic [31:0] d;
      logic v;
      for (int i = 0; i < 3000; i++) begin
         reg_read(A_CMD, d, v);
         if (!d[0]) break;
      end
   endtask

   task automatic load_rx(input int n, input int bad);
      for (int i = 0; i < n; i++) begin
         rxq[8'(rx_n + 8'(i))] = (i == bad) ? (pat(i) ^ 64'h100) : pat(i);
      end
      @(negedge clk);
      rx_n = rx_n + 8'(n);
      for (int i = 0; i < 2000; i++) begin
         if (rx_head == rx_n) break;
         @(negedge clk);
      end
      repeat (3) @(negedge clk);
   endtask

   task automatic tx_run(input int len);
      int base;
      reg_write(A_TXLEN, 32'(len));
      base = tx_seen;
      tx_base = base;
      reg_write(A_CMD, 32'h0);
      wait_idle();
      check("R3 words sent", 64'(tx_seen - base), 64'(len));
      rd_chk("R3 tx count read", A_TXLEN, 32'(len));
      repeat (5) @(negedge clk);
      check("R3 no write after end", 64'(tx_seen - base), 64'(len));
   endtask

   initial begin
      void'($urandom(32'd1234));
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // reset state
      check("R3 reset no write", 64'(tx_wr_en), 64'd0);
      rd_chk("R7 reset cmd", A_CMD, 32'h0);
      rd_chk("R3 reset tx count", A_TXLEN, 32'h0);
      rd_chk("R5 reset rx count", A_RXLEN, 32'h0);
      begin
         logic [31:0] d; logic v;
         reg_read(A_CMD, d, v);
         @(negedge clk);
         check("R2 valid drops", 64'(reg_rd_valid), 64'd0);
      end

      // R1 decode outside area
      rd_chk("R1 outside area", 16'h0004, 32'h0);
      rd_chk("R1 unused offset", 16'h1014, 32'h0);

      // R9 latch and link
      link_up = 1'b1;
      @(negedge clk); irq_in = 1'b1; @(negedge clk); irq_in = 1'b0;
      rd_chk("R9 irq latched and link", A_RST, 32'h0001_0100);
      reg_write(A_RST, 32'h100);
      rd_chk("R9 irq cleared", A_RST, 32'h0001_0000);

      // R10 FIFO status
      rx_level = 16'h1234; force_full = 1'b1;
      repeat (2) @(negedge clk);
      rd_chk("R10 fifo status", A_FFSTS, 32'h8000_1234);
      force_full = 1'b0;

      // R3/R4/R7 generator runs under random full
      tx_run(37);
      tx_run(1);
      tx_run(64);

      // R5/R6 receive clean with verification on
      reg_write(A_CMD, 32'h3);
      rd_chk("R7 cmd bit0=1 stays idle", A_CMD, 32'h0);
      load_rx(50, -1);
      rd_chk("R5 rx count", A_RXLEN, 32'd50);
      rd_chk("R6 clean no error", A_CMD, 32'h0);

      // R6 corrupted word sets sticky flag
      reg_write(A_CMD, 32'h3);
      rd_chk("R7 cmd write clears rx count", A_RXLEN, 32'd0);
      load_rx(40, 10);
      rd_chk("R6 error sticky after good words", A_CMD, 32'h2);
      rd_chk("R5 rx count with error", A_RXLEN, 32'd40);
      reg_write(A_CMD, 32'h3);
      rd_chk("R6 cmd write clears error", A_CMD, 32'h0);

      // R6 verification off ignores corruption
      reg_write(A_CMD, 32'h1);
      load_rx(20, 3);
      rd_chk("R6 verify off no error", A_CMD, 32'h0);
      rd_chk("R5 rx count verify off", A_RXLEN, 32'd20);

      // R8 soft reset in a stalled run
      force_full = 1'b1;
      reg_write(A_TXLEN, 32'd500);
      tx_base = tx_seen;
      reg_write(A_CMD, 32'h0);
      rd_chk("R7 busy while stalled", A_CMD, 32'h1);
      reg_write(A_RST, 32'h1);
      rd_chk("R8 busy cleared", A_CMD, 32'h0);
      rd_chk("R8 tx count cleared", A_TXLEN, 32'h0);
      rd_chk("R8 reset bit reads 0", A_RST, 32'h0001_0000);
      force_full = 1'b0;
      repeat (5) @(negedge clk);
      check("R8 no write after soft reset", 64'(tx_seen - tx_base), 64'd0);

      $display("Result: errors=%0d of %0d checks", n_err + mon_err, n_chk + mon_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      $display("FAIL watchdog: act=timeout exp=finish");
      $display("Result: errors=%0d of %0d checks", n_err + mon_err + 1, n_chk + mon_chk + 1);
      $finish;
   end
endmodule